// File: doc/BRIEF.md
# Speculative Transactional Data Cache

This block is a small direct-mapped, write-back, write-allocate data cache for one core. It also lets that core run hardware transactions without taking any lock. The core sends word loads, word stores and three transaction commands (begin, commit, abort) over one request port. Between a begin and the matching commit, every store stays in the local cache, and each line records whether the transaction has read it or written it. A commit makes all of those buffered words architecturally current in a single cycle. An abort throws them away, so the state outside the cache is exactly what it was before the begin.

Two events break a running transaction. The first is a snoop invalidation, caused by another agent writing to a line that the transaction has read or written. The second is a miss that would replace such a line. In either case the controller aborts on its own. It invalidates every speculatively written line in one step, clears the tracking bits, and reports the cause on a one-cycle status pulse. Transactions whose footprints do not overlap with any snoop run to commit undisturbed. Every cache line and tag is write-back: dirty data leaves only through the memory port, either when the line is replaced or just before a transactional store overwrites committed dirty data.

Back-pressure rules: a core request is taken on a cycle where `cpu_valid` and `cpu_ready` are both high. Until then the core holds `cpu_op`, `cpu_addr` and `cpu_wdata` steady. The memory request follows the same valid/ready rule, and the cache holds its request fields steady until `mem_req_ready`. Read data from memory comes back on `mem_rsp_valid` with no back-pressure, at most one read in flight. Snoops are plain one-cycle strobes and are always taken.

Top module: `spec_txn_cache`

## Requirements
- R1: Outside a transaction, the block acts as a write-back, write-allocate cache. A load miss reads the word from memory. A store hit makes no memory request. A dirty line is written to memory before another address replaces it.
- R2: An accepted begin (cpu_op 2) raises `tx_active` on the next cycle. A begin while `tx_active` is high has no effect. A commit (3) or abort (4) while `tx_active` is low produces no abort pulse and leaves `tx_active` low.
- R3: A store inside a transaction produces no memory write of its value before commit. If it targets a dirty line that no running transaction has written, that line's committed value is first written to memory.
- R4: An accepted commit lowers `tx_active` the next cycle with no abort pulse. The words written by the transaction stay dirty: later loads return them, and they are written to memory when their line is replaced.
- R5: An accepted abort command inside a transaction invalidates every line the transaction wrote, lowers `tx_active` and pulses `abort_valid` with `abort_reason` 0. Later loads of those addresses return the memory values from before the transaction.
- R6: A snoop whose address hits a cached line in the transaction's read set or write set aborts the transaction with `abort_reason` 1.
- R7: A snoop that hits a cached line outside every transaction set invalidates the line without an abort, so the next load of that address reads memory again.
- R8: A load or store miss whose victim line is in the read set or write set aborts the transaction with `abort_reason` 2. The access then completes as an ordinary access.
- R9: Snoops to lines that are not cached, or to lines outside the transaction's sets, leave a running transaction active, and its commit succeeds.
- R10: Load data appears on `cpu_rsp_valid` exactly one cycle after the load is accepted. A memory request holds its fields until accepted. `abort_valid` never stays high for two cycles in a row.
- R11: After reset, `tx_active`, `abort_valid` and `cpu_rsp_valid` are low and every line is invalid, so the first load of any address reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Core request valid |
| cpu_ready | output | 1 | Request taken this cycle |
| cpu_op | input | 3 | 0 load, 1 store, 2 begin, 3 commit, 4 abort |
| cpu_addr | input | IDX_W+TAG_W | Word address: low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | DATA_W | Load data |
| snp_valid | input | 1 | Remote-write invalidation strobe |
| snp_addr | input | IDX_W+TAG_W | Invalidated word address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 write-back, 0 fill read |
| mem_req_addr | output | IDX_W+TAG_W | Memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_rdata | input | DATA_W | Fill data |
| tx_active | output | 1 | A transaction is running |
| abort_valid | output | 1 | One-cycle abort pulse |
| abort_reason | output | 2 | 0 command, 1 snoop conflict, 2 eviction conflict |

## Verification
The bench builds the cache with IDX_W=2, TAG_W=2 and DATA_W=16, which gives four lines over a sixteen-word space. With only four lines, every address shares its line with three others, so sweeps over the whole address space force every replacement, write-back and refill. The same small size makes eviction conflicts easy to reach with two loads, and lets the bench hold its own copy of all sixteen memory words to compare against. The memory model stalls one cycle in every three, which exercises the request-hold rule on both write-backs and fills.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_BEGIN  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_ABORT  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    AB_CMD   = 2'd0,
    AB_SNOOP = 2'd1,
    AB_EVICT = 2'd2
  } reason_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WB    = 2'd1,
    ST_FREQ  = 2'd2,
    ST_FWAIT = 2'd3
  } state_e;
endpackage

// File: rtl/stc_line_flags.sv
// Per-line valid, dirty, read-set and write-set bits with single-cycle
// gang operations for abort and commit.
module stc_line_flags #(
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        acc_idx,
  input  logic                    fill_i,
  input  logic                    wb_done_i,
  input  logic                    st_i,
  input  logic                    ld_tx_i,
  input  logic                    st_tx_i,
  input  logic [IDX_W-1:0]        snp_idx,
  input  logic                    snp_kill_i,
  input  logic                    gang_abort_i,
  input  logic                    gang_commit_i,
  output logic [(1<<IDX_W)-1:0]   valid_o,
  output logic [(1<<IDX_W)-1:0]   dirty_o,
  output logic [(1<<IDX_W)-1:0]   rset_o,
  output logic [(1<<IDX_W)-1:0]   wset_o
);
  localparam int LINES = 1 << IDX_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel, ssel;
    logic v_q, d_q, r_q, w_q;
    assign sel  = (acc_idx == IDX_W'(i));
    assign ssel = (snp_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        r_q <= 1'b0;
        w_q <= 1'b0;
      end else begin
        if (gang_abort_i && w_q)      v_q <= 1'b0;
        else if (snp_kill_i && ssel)  v_q <= 1'b0;
        else if (fill_i && sel)       v_q <= 1'b1;

        if (st_i && sel)                       d_q <= 1'b1;
        else if ((fill_i || wb_done_i) && sel) d_q <= 1'b0;

        if (gang_abort_i || gang_commit_i) begin
          r_q <= 1'b0;
          w_q <= 1'b0;
        end else begin
          if (ld_tx_i && sel) r_q <= 1'b1;
          if (st_tx_i && sel) w_q <= 1'b1;
        end
      end
    end

    assign valid_o[i] = v_q;
    assign dirty_o[i] = d_q;
    assign rset_o[i]  = r_q;
    assign wset_o[i]  = w_q;
  end
endmodule

// File: rtl/stc_line_store.sv
// Tag and data arrays: one write port, one access read port, one snoop tag port.
module stc_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [TAG_W-1:0]  rtag,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  sidx,
  output logic [TAG_W-1:0]  stag
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[widx] <= wtag;
      dat_q[widx] <= wdata;
    end
  end

  assign rtag  = tag_q[ridx];
  assign rdata = dat_q[ridx];
  assign stag  = tag_q[sidx];
endmodule

// File: rtl/spec_txn_cache.sv
module spec_txn_cache
  import stc_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic [2:0]              cpu_op,
  input  logic [IDX_W+TAG_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_rdata,
  input  logic                    snp_valid,
  input  logic [IDX_W+TAG_W-1:0]  snp_addr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_we,
  output logic [IDX_W+TAG_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]       mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_rdata,
  output logic                    tx_active,
  output logic                    abort_valid,
  output logic [1:0]              abort_reason
);
  localparam int ADDR_W = IDX_W + TAG_W;
  localparam int LINES  = 1 << IDX_W;

  logic [IDX_W-1:0]  a_idx, s_idx;
  logic [TAG_W-1:0]  a_tag, s_tag;
  logic [LINES-1:0]  v_vec, d_vec, r_vec, w_vec;
  logic [TAG_W-1:0]  line_tag, snp_line_tag;
  logic [DATA_W-1:0] line_data;

  state_e  st_q, st_d;
  logic    tx_q;
  op_e     op;
  reason_e reason;

  logic hit, line_used, snp_hit, snp_conflict;
  logic ld_done, st_done, fill_go, wb_done;
  logic ab_cmd, ab_evict, abort_go, commit_go, begin_go;

  assign a_idx = cpu_addr[IDX_W-1:0];
  assign a_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign op    = op_e'(cpu_op);

  assign hit          = v_vec[a_idx] && (line_tag == a_tag);
  assign line_used    = r_vec[a_idx] | w_vec[a_idx];
  assign snp_hit      = snp_valid && v_vec[s_idx] && (snp_line_tag == s_tag);
  assign snp_conflict = snp_hit && tx_q && (r_vec[s_idx] | w_vec[s_idx]);

  always_comb begin
    st_d          = st_q;
    cpu_ready     = 1'b0;
    ld_done       = 1'b0;
    st_done       = 1'b0;
    fill_go       = 1'b0;
    wb_done       = 1'b0;
    ab_cmd        = 1'b0;
    ab_evict      = 1'b0;
    commit_go     = 1'b0;
    begin_go      = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = cpu_addr;
    case (st_q)
      ST_IDLE: begin
        // a snoop hit owns the line arrays this cycle; the core waits
        if (cpu_valid && !snp_hit) begin
          case (op)
            OP_BEGIN: begin
              cpu_ready = 1'b1;
              begin_go  = !tx_q;
            end
            OP_COMMIT: begin
              cpu_ready = 1'b1;
              commit_go = tx_q;
            end
            OP_ABORT: begin
              cpu_ready = 1'b1;
              ab_cmd    = tx_q;
            end
            OP_LOAD, OP_STORE: begin
              if (hit) begin
                if (op == OP_STORE && tx_q && d_vec[a_idx] && !w_vec[a_idx]) begin
                  st_d = ST_WB;            // save committed data first
                end else begin
                  cpu_ready = 1'b1;
                  ld_done   = (op == OP_LOAD);
                  st_done   = (op == OP_STORE);
                end
              end else if (tx_q && v_vec[a_idx] && line_used) begin
                ab_evict = 1'b1;           // retried next cycle as plain access
              end else if (v_vec[a_idx] && d_vec[a_idx]) begin
                st_d = ST_WB;
              end else begin
                st_d = ST_FREQ;
              end
            end
            default: cpu_ready = 1'b1;
          endcase
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = {line_tag, a_idx};
        if (mem_req_ready) begin
          wb_done = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_rsp_valid) begin
          fill_go = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign mem_req_wdata = line_data;
  assign abort_go      = snp_conflict | ab_cmd | ab_evict;

  always_comb begin
    if (snp_conflict)  reason = AB_SNOOP;
    else if (ab_evict) reason = AB_EVICT;
    else               reason = AB_CMD;
  end

  stc_line_flags #(.IDX_W(IDX_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_idx       (a_idx),
    .fill_i        (fill_go),
    .wb_done_i     (wb_done),
    .st_i          (st_done),
    .ld_tx_i       (ld_done && tx_q),
    .st_tx_i       (st_done && tx_q),
    .snp_idx       (s_idx),
    .snp_kill_i    (snp_hit),
    .gang_abort_i  (abort_go),
    .gang_commit_i (commit_go),
    .valid_o       (v_vec),
    .dirty_o       (d_vec),
    .rset_o        (r_vec),
    .wset_o        (w_vec)
  );

  stc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (st_done || fill_go),
    .widx  (a_idx),
    .wtag  (a_tag),
    .wdata (fill_go ? mem_rsp_rdata : cpu_wdata),
    .ridx  (a_idx),
    .rtag  (line_tag),
    .rdata (line_data),
    .sidx  (s_idx),
    .stag  (snp_line_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      tx_q          <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      abort_valid   <= 1'b0;
      abort_reason  <= 2'd0;
    end else begin
      st_q <= st_d;
      if (abort_go || commit_go) tx_q <= 1'b0;
      else if (begin_go)         tx_q <= 1'b1;
      cpu_rsp_valid <= ld_done;
      if (ld_done) cpu_rsp_rdata <= line_data;
      abort_valid <= abort_go;
      if (abort_go) abort_reason <= reason;
    end
  end

  assign tx_active = tx_q;
endmodule

// File: rtl/stc_checker.sv
module stc_checker
  import stc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [2:0]        cpu_op,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              tx_active,
  input logic              abort_valid,
  input logic [1:0]        abort_reason
);
  // R10
  load_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_valid && cpu_ready && cpu_op == OP_LOAD));

  // R10
  abort_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |=> !abort_valid);

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R5
  abort_ends_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> (!tx_active && $past(tx_active)));

  // R2
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(cpu_valid && cpu_ready && cpu_op == OP_BEGIN));

  // R4
  commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_op == OP_COMMIT && tx_active) |=> (!tx_active && !abort_valid));

  // R6 R8
  reason_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> (abort_reason != 2'd3));
endmodule

bind spec_txn_cache stc_checker #(.ADDR_W(IDX_W + TAG_W), .DATA_W(DATA_W)) u_stc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_valid     (cpu_valid),
  .cpu_ready     (cpu_ready),
  .cpu_op        (cpu_op),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .tx_active     (tx_active),
  .abort_valid   (abort_valid),
  .abort_reason  (abort_reason)
);

// File: tb/test_spec_txn_cache.sv
`timescale 1ns/1ps
module test_spec_txn_cache;
  import stc_pkg::*;

  localparam int IW = 2;
  localparam int TW = 2;
  localparam int DW = 16;
  localparam int AW = IW + TW;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0;
  logic cpu_ready;
  logic [2:0] cpu_op = 3'd0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic mem_req_valid, mem_req_we, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;
  logic tx_active, abort_valid;
  logic [1:0] abort_reason;

  always #2 clk = ~clk;

  spec_txn_cache #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) i_spec_txn_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .tx_active(tx_active), .abort_valid(abort_valid), .abort_reason(abort_reason)
  );

  // memory model: stalls one cycle in three, fill data one cycle after acceptance
  logic [DW-1:0] mem [NA];
  int cyc, wr_cnt, rd_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) mem[i] <= DW'(i * 7 + 3);
      cyc <= 0; wr_cnt <= 0; rd_cnt <= 0;
      mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end
  assign mem_req_ready = (cyc % 3) != 2;

  // abort pulse monitor
  int ab_cnt = 0, ab_seen = 0, ab_double = 0, ab_last = -1;
  logic ab_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && abort_valid) begin
      ab_cnt = ab_cnt + 1;
      ab_last = int'(abort_reason);
      if (ab_prev) ab_double = ab_double + 1;
    end
    ab_prev = rst_n && abort_valid;
  end

  int checks = 0, errors = 0;
  int arch [NA];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input op_e o, input int a, input int wd, output logic [DW-1:0] rd, output logic rv);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = o; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cpu_valid = 1'b0;
    rd = cpu_rsp_rdata;
    rv = cpu_rsp_valid;
  endtask

  task automatic ld(input int a, input int exp, input string req);
    logic [DW-1:0] d;
    logic v;
    xfer(OP_LOAD, a, 0, d, v);
    check(v && int'(d) == exp, req, $sformatf("load addr %0d", a), v ? int'(d) : -1, exp);
  endtask

  task automatic st(input int a, input int d);
    logic [DW-1:0] x;
    logic v;
    xfer(OP_STORE, a, d, x, v);
  endtask

  task automatic cmd(input op_e o);
    logic [DW-1:0] x;
    logic v;
    xfer(o, 0, 0, x, v);
  endtask

  task automatic snoop(input int a);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = AW'(a);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic expect_abort(input string req, input int rsn);
    repeat (2) @(negedge clk);
    check(ab_cnt == ab_seen + 1, req, "abort count", ab_cnt - ab_seen, 1);
    check(ab_last == rsn, req, "abort reason", ab_last, rsn);
    check(tx_active == 1'b0, req, "tx_active after abort", int'(tx_active), 0);
    ab_seen = ab_cnt;
  endtask

  task automatic expect_no_abort(input string req, input bit tx_exp);
    repeat (2) @(negedge clk);
    check(ab_cnt == ab_seen, req, "no abort", ab_cnt - ab_seen, 0);
    check(tx_active == tx_exp, req, "tx_active", int'(tx_active), int'(tx_exp));
    ab_seen = ab_cnt;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < NA; i++) arch[i] = i * 7 + 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(tx_active == 0 && abort_valid == 0 && cpu_rsp_valid == 0, "R11", "reset outputs",
          int'({tx_active, abort_valid, cpu_rsp_valid}), 0);
    r0 = rd_cnt;
    ld(0, arch[0], "R11");
    check(rd_cnt == r0 + 1, "R11", "first load reads memory", rd_cnt - r0, 1);

    // R1 sweep: load every address, store every address, reload every address
    for (int a = 0; a < NA; a++) ld(a, arch[a], "R1");
    for (int a = 0; a < NA; a++) begin
      st(a, a * 11 + 5);
      arch[a] = a * 11 + 5;
    end
    for (int a = 0; a < NA; a++) begin
      if (a < NA - (1 << IW)) check(int'(mem[a]) == a * 11 + 5, "R1", $sformatf("written back %0d", a), int'(mem[a]), a * 11 + 5);
      else check(int'(mem[a]) == a * 7 + 3, "R1", $sformatf("still cached %0d", a), int'(mem[a]), a * 7 + 3);
    end
    for (int a = 0; a < NA; a++) ld(a, arch[a], "R1");
    w0 = wr_cnt;
    st(13, 100); arch[13] = 100;
    check(wr_cnt == w0, "R1", "store hit no traffic", wr_cnt - w0, 0);

    // R2 commands outside a transaction and a repeated begin
    cmd(OP_COMMIT);
    expect_no_abort("R2", 1'b0);
    cmd(OP_ABORT);
    expect_no_abort("R2", 1'b0);
    cmd(OP_BEGIN);
    expect_no_abort("R2", 1'b1);
    cmd(OP_BEGIN);
    expect_no_abort("R2", 1'b1);

    // R3 then R5: spec store over committed dirty data, explicit abort
    w0 = wr_cnt;
    st(13, 200);
    check(wr_cnt == w0 + 1 && int'(mem[13]) == 100, "R3", "committed copy saved", int'(mem[13]), 100);
    st(14, 300);
    ld(13, 200, "R3");
    check(wr_cnt == w0 + 1, "R3", "no speculative write", wr_cnt - w0, 1);
    cmd(OP_ABORT);
    expect_abort("R5", 0);
    ld(13, arch[13], "R5");
    ld(14, arch[14], "R5");
    check(int'(mem[14]) == arch[14] && wr_cnt == w0 + 1, "R5", "memory untouched", int'(mem[14]), arch[14]);

    // R4 commit, then eviction writes the committed word
    cmd(OP_BEGIN);
    st(5, 55);
    cmd(OP_COMMIT);
    expect_no_abort("R4", 1'b0);
    arch[5] = 55;
    ld(5, 55, "R4");
    ld(9, arch[9], "R4");
    check(int'(mem[5]) == 55, "R4", "committed word reached memory", int'(mem[5]), 55);

    // R6 snoop on read set and on write set
    cmd(OP_BEGIN);
    ld(2, arch[2], "R6");
    snoop(2);
    expect_abort("R6", 1);
    cmd(OP_BEGIN);
    st(3, 77);
    snoop(3);
    expect_abort("R6", 1);
    ld(3, arch[3], "R6");

    // R7 snoop on an untracked line
    ld(0, arch[0], "R7");
    snoop(0);
    expect_no_abort("R7", 1'b0);
    r0 = rd_cnt;
    ld(0, arch[0], "R7");
    check(rd_cnt == r0 + 1, "R7", "refetch after invalidation", rd_cnt - r0, 1);

    // R9 disjoint snoops leave the transaction alone
    cmd(OP_BEGIN);
    ld(1, arch[1], "R9");
    snoop(0);
    expect_no_abort("R9", 1'b1);
    st(0, 99);
    snoop(4);
    snoop(10);
    expect_no_abort("R9", 1'b1);
    cmd(OP_COMMIT);
    expect_no_abort("R9", 1'b0);
    arch[0] = 99;
    ld(0, 99, "R9");

    // R8 eviction of read-set and write-set lines
    cmd(OP_BEGIN);
    ld(1, arch[1], "R8");
    ld(5, arch[5], "R8");
    expect_abort("R8", 2);
    cmd(OP_BEGIN);
    st(2, 66);
    ld(6, arch[6], "R8");
    expect_abort("R8", 2);
    ld(2, arch[2], "R8");

    // R10 abort pulses were single cycles
    check(ab_double == 0, "R10", "abort pulse width", ab_double, 0);

    summary();
    $finish;
  end
endmodule